// File: doc/BRIEF.md
# Predicated Vector Absolute Value Unit

This unit computes the magnitude of every element of a wide vector operand in a fixed-length pipeline. The element format is chosen per operation: signed two's-complement integers of 8, 16 or 32 bits, or IEEE half- or single-precision floats. All formats share one datapath whose total width is a parameter (256 bits by default). Each operation carries a predicate mask with one bit per byte. It also carries the current contents of the destination, so that lanes switched off by the mask can keep their previous value (merge predication).

An operation is issued by raising `iss_valid` for one cycle with its operands. The unit takes a new operation on every cycle and has no backpressure. Exactly five cycles later `res_valid` rises with the merged result on `res_data`. Results come out in issue order. The unit has no other effect: it keeps no state beyond its pipeline and signals nothing else.

Top module: `vec_abs_unit`

## Requirements
- R1: For an active lane of a signed integer type, the result lane is the two's-complement magnitude of the source lane (type codes: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit integer).
- R2: The integer magnitude of the most negative value wraps, so the result equals the source bit pattern (0x80, 0x8000, 0x80000000).
- R3: For an active lane of a float type (code 3 = 16-bit, code 4 = 32-bit), only the top bit of the lane is cleared and all lower bits are copied, including for NaN, infinity and negative zero.
- R4: Every byte of a lane whose predicate is 0 equals the same byte of `iss_old` from the same operation.
- R5: Mask bit k covers byte k of the vector. For an element wider than a byte, only the mask bit of the element's lowest byte decides whether it is active, and the other mask bits of that element are ignored.
- R6: The type codes 5, 6 and 7 are illegal, and the whole result then equals `iss_old`.
- R7: `res_valid` equals `iss_valid` delayed by exactly 5 clock cycles, and the data presented with it belongs to that issued operation.
- R8: Operations issued on consecutive cycles each produce their own result on consecutive cycles, in issue order.
- R9: A synchronous active-high `rst` clears the pipeline. Operations presented while `rst` is high produce no result, and `res_valid` stays low after reset until 5 cycles after the first issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | An operation is issued this cycle |
| iss_type | input | 3 | Element type code of the operation |
| iss_mask | input | VEC_W/8 | Per-byte predicate, 1 = active |
| iss_src | input | VEC_W | Source vector |
| iss_old | input | VEC_W | Previous destination contents, kept on inactive lanes |
| res_valid | output | 1 | Result of the operation issued 5 cycles earlier is present |
| res_data | output | VEC_W | Merged result vector |

## Verification
The bench aims at the most negative integer of each width. A design that saturated or sign-extended there would return 0x7F.. or a wrong neighbour byte instead of the wrapped pattern. Float lanes get negative NaN, negative infinity and negative zero, which a design that negated the value or cleared the wrong bit would corrupt. Masks with only the non-lowest bits of a wide element set catch a design that ORs the granule bits, and illegal type codes catch one that still writes the magnitude. Back-to-back bursts, gaps in the issue stream and operations offered during reset expose a stage that drops, duplicates or mixes up the operands of neighbouring operations.

// File: rtl/vabs_pkg.sv
package vabs_pkg;

    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int HALF_W     = WORD_W / 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } elem_size_e;

    typedef struct packed {
        logic       legal;
        logic       is_flt;
        elem_size_e size;
    } elem_cfg_t;

    function automatic elem_cfg_t decode_type(input logic [2:0] code);
        elem_cfg_t c;
        c.legal  = 1'b1;
        c.is_flt = 1'b0;
        c.size   = SZ_BYTE;
        case (code)
            3'd0: c.size = SZ_BYTE;
            3'd1: c.size = SZ_HALF;
            3'd2: c.size = SZ_WORD;
            3'd3: begin c.size = SZ_HALF; c.is_flt = 1'b1; end
            3'd4: begin c.size = SZ_WORD; c.is_flt = 1'b1; end
            default: c.legal = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/vabs_word.sv
module vabs_word
    import vabs_pkg::*;
(
    input  elem_cfg_t              cfg,
    input  logic [WORD_BYTES-1:0]  mask,
    input  logic [WORD_W-1:0]      src,
    input  logic [WORD_W-1:0]      old,
    output logic [WORD_W-1:0]      res
);

    localparam int NHALF = WORD_W / HALF_W;

    logic [WORD_W-1:0]     mag_b;
    logic [WORD_W-1:0]     mag_h;
    logic [WORD_W-1:0]     mag_w;
    logic [WORD_W-1:0]     flt_h;
    logic [WORD_W-1:0]     flt_w;
    logic [WORD_W-1:0]     mag;
    logic [WORD_BYTES-1:0] act;

    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
        logic [7:0] x;
        assign x = src[b*8 +: 8];
        assign mag_b[b*8 +: 8] = x[7] ? (~x + 8'd1) : x;
    end

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        logic [HALF_W-1:0] x;
        assign x = src[h*HALF_W +: HALF_W];
        assign mag_h[h*HALF_W +: HALF_W] = x[HALF_W-1] ? (~x + HALF_W'(1)) : x;
        assign flt_h[h*HALF_W +: HALF_W] = {1'b0, x[HALF_W-2:0]};
    end

    assign mag_w = src[WORD_W-1] ? (~src + WORD_W'(1)) : src;
    assign flt_w = {1'b0, src[WORD_W-2:0]};

    always_comb begin
        mag = mag_b;
        act = '0;
        case (cfg.size)
            SZ_BYTE: begin
                mag = mag_b;
                act = mask;
            end
            SZ_HALF: begin
                mag = cfg.is_flt ? flt_h : mag_h;
                for (int h = 0; h < NHALF; h++) begin
                    act[h*2]     = mask[h*2];
                    act[h*2 + 1] = mask[h*2];
                end
            end
            SZ_WORD: begin
                mag = cfg.is_flt ? flt_w : mag_w;
                act = {WORD_BYTES{mask[0]}};
            end
            default: begin
                mag = mag_b;
                act = '0;
            end
        endcase
        if (!cfg.legal) begin
            act = '0;
        end
        for (int b = 0; b < WORD_BYTES; b++) begin
            res[b*8 +: 8] = act[b] ? mag[b*8 +: 8] : old[b*8 +: 8];
        end
    end

endmodule

// File: rtl/vabs_delay.sv
module vabs_delay #(
    parameter int W     = 32,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vld_i,
    input  logic [W-1:0] dat_i,
    output logic         vld_o,
    output logic [W-1:0] dat_o
);

    if (DEPTH == 0) begin : g_wire
        assign vld_o = vld_i;
        assign dat_o = dat_i;
    end else begin : g_regs
        logic [DEPTH-1:0] vld_d, vld_q;
        logic [W-1:0]     dat_d [DEPTH];
        logic [W-1:0]     dat_q [DEPTH];

        always_comb begin
            vld_d[0] = vld_i;
            dat_d[0] = dat_i;
            for (int i = 1; i < DEPTH; i++) begin
                vld_d[i] = vld_q[i-1];
                dat_d[i] = dat_q[i-1];
            end
        end

        always_ff @(posedge clk) begin
            for (int i = 0; i < DEPTH; i++) begin
                dat_q[i] <= dat_d[i];
            end
            if (rst) begin
                vld_q <= '0;
            end else begin
                vld_q <= vld_d;
            end
        end

        assign vld_o = vld_q[DEPTH-1];
        assign dat_o = dat_q[DEPTH-1];
    end

endmodule

// File: rtl/vec_abs_unit.sv
module vec_abs_unit
    import vabs_pkg::*;
#(
    parameter int VEC_W   = 256,
    parameter int LATENCY = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 iss_valid,
    input  logic [2:0]           iss_type,
    input  logic [VEC_W/8-1:0]   iss_mask,
    input  logic [VEC_W-1:0]     iss_src,
    input  logic [VEC_W-1:0]     iss_old,
    output logic                 res_valid,
    output logic [VEC_W-1:0]     res_data
);

    localparam int MASK_W = VEC_W / 8;
    localparam int NWORD  = VEC_W / WORD_W;
    localparam int TAIL   = LATENCY - 2;

    typedef struct packed {
        logic              vld;
        elem_cfg_t         cfg;
        logic [MASK_W-1:0] mask;
        logic [VEC_W-1:0]  src;
        logic [VEC_W-1:0]  old;
    } opnd_t;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] data;
    } rslt_t;

    opnd_t            op_d, op_q;
    rslt_t            rs_d, rs_q;
    logic [VEC_W-1:0] word_res;

    for (genvar w = 0; w < NWORD; w++) begin : g_word
        vabs_word u_word (
            .cfg  (op_q.cfg),
            .mask (op_q.mask[w*WORD_BYTES +: WORD_BYTES]),
            .src  (op_q.src[w*WORD_W +: WORD_W]),
            .old  (op_q.old[w*WORD_W +: WORD_W]),
            .res  (word_res[w*WORD_W +: WORD_W])
        );
    end

    always_comb begin
        op_d.vld  = iss_valid;
        op_d.cfg  = decode_type(iss_type);
        op_d.mask = iss_mask;
        op_d.src  = iss_src;
        op_d.old  = iss_old;
        rs_d.vld  = op_q.vld;
        rs_d.data = word_res;
    end

    always_ff @(posedge clk) begin
        op_q <= op_d;
        rs_q <= rs_d;
        if (rst) begin
            op_q.vld <= 1'b0;
            rs_q.vld <= 1'b0;
        end
    end

    vabs_delay #(
        .W     (VEC_W),
        .DEPTH (TAIL)
    ) u_tail (
        .clk   (clk),
        .rst   (rst),
        .vld_i (rs_q.vld),
        .dat_i (rs_q.data),
        .vld_o (res_valid),
        .dat_o (res_data)
    );

endmodule

// File: rtl/vabs_checker.sv
module vabs_checker #(
    parameter int VEC_W   = 256,
    parameter int LATENCY = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               iss_valid,
    input logic [2:0]         iss_type,
    input logic [VEC_W/8-1:0] iss_mask,
    input logic [VEC_W-1:0]   iss_src,
    input logic [VEC_W-1:0]   iss_old,
    input logic               res_valid,
    input logic [VEC_W-1:0]   res_data
);

    localparam int MASK_W = VEC_W / 8;
    localparam int NWORD  = VEC_W / 32;

    logic [LATENCY-1:0] v_sr;
    logic [2:0]         t_sr [LATENCY];
    logic [MASK_W-1:0]  m_sr [LATENCY];
    logic [VEC_W-1:0]   s_sr [LATENCY];
    logic [VEC_W-1:0]   o_sr [LATENCY];

    always_ff @(posedge clk) begin
        t_sr[0] <= iss_type;
        m_sr[0] <= iss_mask;
        s_sr[0] <= iss_src;
        o_sr[0] <= iss_old;
        for (int i = 1; i < LATENCY; i++) begin
            t_sr[i] <= t_sr[i-1];
            m_sr[i] <= m_sr[i-1];
            s_sr[i] <= s_sr[i-1];
            o_sr[i] <= o_sr[i-1];
        end
        if (rst) begin
            v_sr <= '0;
        end else begin
            v_sr <= {v_sr[LATENCY-2:0], iss_valid};
        end
    end

    logic [2:0]        t_at;
    logic [MASK_W-1:0] m_at;
    logic [VEC_W-1:0]  s_at, o_at;
    logic              keep_ok, flt_ok, int_ok;

    assign t_at = t_sr[LATENCY-1];
    assign m_at = m_sr[LATENCY-1];
    assign s_at = s_sr[LATENCY-1];
    assign o_at = o_sr[LATENCY-1];

    always_comb begin
        keep_ok = 1'b1;
        flt_ok  = 1'b1;
        int_ok  = 1'b1;
        for (int b = 0; b < MASK_W; b++) begin
            logic gran;
            case (t_at)
                3'd1, 3'd3: gran = m_at[b & ~1];
                3'd2, 3'd4: gran = m_at[b & ~3];
                default:    gran = m_at[b];
            endcase
            if (!gran && res_data[b*8 +: 8] != o_at[b*8 +: 8]) begin
                keep_ok = 1'b0;
            end
        end
        for (int w = 0; w < NWORD; w++) begin
            if (m_at[w*4]) begin
                if (t_at == 3'd4 &&
                    res_data[w*32 +: 32] != {1'b0, s_at[w*32 +: 31]}) begin
                    flt_ok = 1'b0;
                end
                if (t_at == 3'd2 && res_data[w*32 + 31] &&
                    s_at[w*32 +: 32] != 32'h8000_0000) begin
                    int_ok = 1'b0;
                end
            end
        end
    end

    p_valid_delay_r7: assert property (@(posedge clk) disable iff (rst)
        res_valid == v_sr[LATENCY-1]);

    p_reset_clears_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !res_valid);

    p_inactive_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (res_valid && t_at <= 3'd4) |-> keep_ok);

    p_illegal_old_r6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && t_at > 3'd4) |-> res_data == o_at);

    p_float_sign_r3: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> flt_ok);

    p_int_magnitude_r1: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> int_ok);

endmodule

bind vec_abs_unit vabs_checker #(
    .VEC_W   (VEC_W),
    .LATENCY (LATENCY)
) u_vabs_checker (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .iss_type  (iss_type),
    .iss_mask  (iss_mask),
    .iss_src   (iss_src),
    .iss_old   (iss_old),
    .res_valid (res_valid),
    .res_data  (res_data)
);

// File: tb/vec_abs_unit_tb_top.sv
module vec_abs_unit_tb_top;

    localparam int VW  = 256;
    localparam int MW  = VW / 8;
    localparam int LAT = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          iss_valid = 1'b0;
    logic [2:0]    iss_type = '0;
    logic [MW-1:0] iss_mask = '0;
    logic [VW-1:0] iss_src = '0;
    logic [VW-1:0] iss_old = '0;
    logic          res_valid;
    logic [VW-1:0] res_data;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;
    bit done     = 0;

    logic          ring_v [8];
    logic [VW-1:0] ring_d [8];
    string         ring_tag [8];

    always #5 clk = ~clk;

    vec_abs_unit #(.VEC_W(VW), .LATENCY(LAT)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .iss_valid (iss_valid),
        .iss_type  (iss_type),
        .iss_mask  (iss_mask),
        .iss_src   (iss_src),
        .iss_old   (iss_old),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    function automatic logic [VW-1:0] model(input logic [2:0] t, input logic [MW-1:0] m,
                                            input logic [VW-1:0] s, input logic [VW-1:0] o);
        logic [VW-1:0] r;
        logic [VW-1:0] field;
        int            ew;
        bit            flt;
        logic [63:0]   wm, x, y;
        r = o;
        if (t > 3'd4) return r;
        ew  = (t == 3'd0) ? 8 : (t == 3'd1 || t == 3'd3) ? 16 : 32;
        flt = (t >= 3'd3);
        wm  = (64'd1 << ew) - 64'd1;
        for (int e = 0; e < VW / ew; e++) begin
            int lo;
            lo = e * ew;
            if (m[lo / 8]) begin
                x = 64'(s >> lo) & wm;
                if (flt) y = x & ~(64'd1 << (ew - 1));
                else     y = x[ew-1] ? ((~x + 64'd1) & wm) : x;
                field = VW'(wm) << lo;
                r = (r & ~field) | (VW'(y) << lo);
            end
        end
        return r;
    endfunction

    task automatic check_out();
        int idx;
        idx = (cyc - LAT) & 7;
        checks++;
        if (res_valid !== ring_v[idx]) begin
            failures++;
            $display("FAIL R7 cycle %0d res_valid actual=%0b expected=%0b", cyc, res_valid, ring_v[idx]);
        end else if (ring_v[idx]) begin
            checks++;
            if (res_data !== ring_d[idx]) begin
                failures++;
                $display("FAIL %s cycle %0d res_data actual=%h expected=%h",
                         ring_tag[idx], cyc, res_data, ring_d[idx]);
            end
        end
    endtask

    task automatic step(input logic r, input logic v, input logic [2:0] t,
                        input logic [MW-1:0] m, input logic [VW-1:0] s,
                        input logic [VW-1:0] o, input string tag);
        int idx;
        @(negedge clk);
        check_out();
        rst       = r;
        iss_valid = v;
        iss_type  = t;
        iss_mask  = m;
        iss_src   = s;
        iss_old   = o;
        idx = cyc & 7;
        ring_v[idx]   = v & ~r;
        ring_d[idx]   = model(t, m, s, o);
        ring_tag[idx] = tag;
        cyc++;
    endtask

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] z;
        for (int i = 0; i < VW / 32; i++) z[i*32 +: 32] = $urandom;
        return z;
    endfunction

    function automatic logic [MW-1:0] rnd_mask();
        return MW'($urandom);
    endfunction

    initial begin
        logic [VW-1:0] oldv;
        logic [VW-1:0] srcv;
        for (int i = 0; i < 8; i++) begin
            ring_v[i] = 1'b0;
            ring_d[i] = '0;
            ring_tag[i] = "R7";
        end
        void'($urandom(32'd20240611));
        oldv = rnd_vec();

        // R9: operations offered during reset must vanish
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 3'd0, '1, rnd_vec(), oldv, "R9");
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            failures++;
            $display("FAIL R9 reset state res_valid actual=%0b expected=0", res_valid);
        end
        // R9: idle cycles after reset, then first issue
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 3'd0, '0, '0, '0, "R9");

        // R2: most negative values wrap
        step(1'b0, 1'b1, 3'd0, '1, {MW{8'h80}}, oldv, "R2");
        step(1'b0, 1'b1, 3'd1, '1, {(VW/16){16'h8000}}, oldv, "R2");
        step(1'b0, 1'b1, 3'd2, '1, {(VW/32){32'h8000_0000}}, oldv, "R2");
        // R1: plain negatives and positives per width
        step(1'b0, 1'b1, 3'd0, '1, {(VW/16){16'hFF05}}, oldv, "R1");
        step(1'b0, 1'b1, 3'd1, '1, {(VW/32){32'hFFFE_1234}}, oldv, "R1");
        step(1'b0, 1'b1, 3'd2, '1, {(VW/32){32'hFFFF_FFFF}}, oldv, "R1");
        // R3: negative NaN, infinity and zero
        step(1'b0, 1'b1, 3'd3, '1, {(VW/64){64'hFE00_FC00_8000_BC00}}, oldv, "R3");
        step(1'b0, 1'b1, 3'd4, '1, {(VW/64){64'hFFC0_0000_8000_0000}}, oldv, "R3");
        step(1'b0, 1'b1, 3'd4, '1, {(VW/64){64'hFF80_0000_7F80_0001}}, oldv, "R3");
        // R5: upper granule bits alone do not activate a wide element
        step(1'b0, 1'b1, 3'd2, {(MW/4){4'b1110}}, {(VW/32){32'h8000_0001}}, oldv, "R5");
        step(1'b0, 1'b1, 3'd2, {(MW/4){4'b0001}}, {(VW/32){32'h8000_0001}}, oldv, "R5");
        step(1'b0, 1'b1, 3'd3, {(MW/2){2'b10}}, {(VW/16){16'hC000}}, oldv, "R5");
        // R4: zero mask keeps everything
        step(1'b0, 1'b1, 3'd0, '0, {MW{8'hFF}}, oldv, "R4");
        // R6: illegal codes keep old contents
        for (int c = 5; c < 8; c++) step(1'b0, 1'b1, 3'(c), '1, {MW{8'hF0}}, oldv, "R6");
        // R8: back-to-back burst of 16
        for (int i = 0; i < 16; i++) step(1'b0, 1'b1, 3'(i % 5), rnd_mask(), rnd_vec(), rnd_vec(), "R8");
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 3'd0, '0, '0, '0, "R7");

        // Random mix with gaps
        for (int i = 0; i < 800; i++) begin
            int r;
            logic [2:0] t;
            string tg;
            r = $urandom % 16;
            t = (r < 14) ? 3'(r % 5) : 3'(5 + ($urandom % 3));
            srcv = rnd_vec();
            if ($urandom % 8 == 0) srcv[31:0] = 32'h8000_0000;
            tg = (t > 3'd4) ? "R6" : (t >= 3'd3) ? "R3" : "R1";
            step(1'b0, ($urandom % 5) != 0, t, rnd_mask(), srcv, rnd_vec(), tg);
        end
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 3'd0, '0, '0, '0, "R7");

        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL R7 watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule